// File: doc/BRIEF.md
# Memory Access Checker and Exception Encoder

This block sits beside the address translation unit of a processor core and rules on one memory access per cycle. It takes the virtual address, the access size and kind, the current privilege mode, the translation-enable and store-queue user-lock controls, and the result of a page table lookup that is done elsewhere. From these it decides whether the access proceeds, and with which physical address, or faults. A fault is reported as an exception event code and a vector offset.

Checks run in a fixed priority order:
1. Alignment to the access size.
2. Store-queue window rules for data accesses.
3. The user-mode ban on the upper half of the address space.
4. The untranslated segments.
5. When translation applies, the lookup outcome and the page permission bits.

On any fault, including a lookup that matched more than one entry, the block keeps the faulting virtual address and its page number. A fault handler can read both later. These two registers hold their values until the next fault.

Results are registered. An access presented with `valid_i` high at one rising edge has its verdict on the outputs for the cycle after that edge.

Top module: `mmu_access_checker`

## Requirements
- R1: An access whose address is not a multiple of its size is a bad-address fault. `size_i` encodes the size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. This check has the highest priority.
- R2: A user-mode access (`priv_i`=0) with address bit 31 set is a bad-address fault. The one exception is a data access inside the store-queue window 0xE0000000 to 0xE3FFFFFF. An instruction fetch from that window in user mode also faults.
- R3: The address passes unchanged and the lookup inputs are ignored in three cases:
  - `xlat_en_i`=0;
  - address bits [31:29] are 100, 101 or 111;
  - privileged mode and address bits [31:26] are 011111.
- R4: A data access inside the store-queue window follows these rules:
  - It faults as a bad address if address bits [1:0] are not zero.
  - It faults as a bad address if `sq_user_lock_i`=1 in user mode.
  - Otherwise, with `xlat_en_i`=0, the result is `sq_base1_i` (when address bit 5 is 1) or `sq_base0_i` (when it is 0), plus the address with bits [4:0] cleared, modulo 2^32.
  - With `xlat_en_i`=1, the result is `tlb_addr_i` with bits [4:0] cleared, after the lookup checks of R5 to R7.
- R5: On a translated access, `tlb_multi_i`=1 raises `mhit_o` and no exception. Otherwise `tlb_hit_i`=0 is a lookup-miss fault. Otherwise the physical address is `tlb_addr_i` (R4 aside).
- R6: On a translated hit, a page with `tlb_pr_i[1]`=0 accessed in user mode is a protection fault. This applies to every access kind.
- R7: A translated data write (`kind_i`=2) on a hit that passes R6 has two further checks. `tlb_pr_i[0]`=0 is a protection fault. Otherwise `tlb_dirty_i`=0 is a first-write fault.
- R8: Exception codes are as follows (`kind_i` 0 = instruction fetch, 1 = data read, 2 = data write):

  | Fault | Data write | Data read or instruction fetch |
  |---|---|---|
  | Lookup miss | 0x060 | 0x040 |
  | Protection | 0x0C0 | 0x0A0 |
  | First write | 0x080 | (write only) |
  | Bad address | 0x100 | 0x0E0 |

  Code and vector read 0 when there is no exception.
- R9: The vector offset is 0x400 for lookup-miss faults and 0x100 for every other fault.
- R10: At the edge that registers a fault or a multi-hit, `tea_o` takes the virtual address and `vpn_o` takes address bits [31:10]. At all other edges both hold their value.
- R11: `done_o` is high for exactly the cycle after an edge with `valid_i` high. `exc_o` and `mhit_o` are only ever high together with `done_o`, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access presented this cycle |
| addr_i | input | 32 | Virtual address |
| size_i | input | 2 | Access size code (R1) |
| kind_i | input | 2 | 0 fetch, 1 read, 2 write |
| priv_i | input | 1 | 1 = privileged mode |
| xlat_en_i | input | 1 | Address translation enabled |
| sq_user_lock_i | input | 1 | Forbid store-queue access from user mode |
| sq_base0_i | input | 32 | Store-queue target base, address bit 5 = 0 |
| sq_base1_i | input | 32 | Store-queue target base, address bit 5 = 1 |
| tlb_hit_i | input | 1 | Lookup found exactly one entry |
| tlb_multi_i | input | 1 | Lookup found several entries |
| tlb_addr_i | input | 32 | Translated address from the lookup |
| tlb_pr_i | input | 2 | Page permission: [1] user allowed, [0] writable |
| tlb_dirty_i | input | 1 | Page dirty bit |
| done_o | output | 1 | Verdict valid this cycle |
| exc_o | output | 1 | Access faulted |
| mhit_o | output | 1 | Lookup multi-hit (reset-class event) |
| exc_code_o | output | 12 | Exception event code |
| exc_vec_o | output | 12 | Exception vector offset |
| phys_o | output | 32 | Resulting physical address |
| tea_o | output | 32 | Last faulting virtual address |
| vpn_o | output | 22 | Page number of the last faulting address |

## Verification
A wrong priority between the checks shows at once as a wrong event code or a wrong pass/fail on the cycle after the access. Typical cases are a misaligned store-queue write reported as a lookup miss, or a user write to a read-only clean page reported as first-write. A fault register that fails to hold is only visible on a later access. For that reason the bench tracks the expected fault address across the whole sweep and compares it after every access, faulting or not. A broken strobe pipeline shows as `done_o` one cycle early or late, or as a verdict outside the `done_o` cycle.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
  localparam int EXC_W = 12;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_BAD  = 3'd1,
    ERR_MISS = 3'd2,
    ERR_MHIT = 3'd3,
    ERR_PROT = 3'd4,
    ERR_FW   = 3'd5
  } acc_err_e;

  localparam logic [EXC_W-1:0] EV_MISS_W = 12'h060;
  localparam logic [EXC_W-1:0] EV_MISS_R = 12'h040;
  localparam logic [EXC_W-1:0] EV_PROT_W = 12'h0C0;
  localparam logic [EXC_W-1:0] EV_PROT_R = 12'h0A0;
  localparam logic [EXC_W-1:0] EV_FW     = 12'h080;
  localparam logic [EXC_W-1:0] EV_BAD_W  = 12'h100;
  localparam logic [EXC_W-1:0] EV_BAD_R  = 12'h0E0;
  localparam logic [EXC_W-1:0] VEC_MISS  = 12'h400;
  localparam logic [EXC_W-1:0] VEC_OTHER = 12'h100;
endpackage

// File: rtl/mmu_chk_region.sv
module mmu_chk_region
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_SH = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic              priv_i,
  input  logic              xlat_en_i,
  input  logic              sq_user_lock_i,
  input  logic [ADDR_W-1:0] sq_base0_i,
  input  logic [ADDR_W-1:0] sq_base1_i,
  input  logic              tlb_hit_i,
  input  logic              tlb_multi_i,
  input  logic [ADDR_W-1:0] tlb_addr_i,
  input  logic [1:0]        tlb_pr_i,
  input  logic              tlb_dirty_i,
  output acc_err_e          err_o,
  output logic [ADDR_W-1:0] phys_o
);
  localparam int TOP = ADDR_W - 1;

  logic [2:0]        align_mask;
  logic              misal, in_sq, is_data, is_write, seg_bypass, priv_win;
  logic              use_tlb;
  logic [ADDR_W-1:0] line_addr, sq_base;

  assign align_mask = 3'((4'd1 << size_i) - 4'd1);
  assign misal      = |(addr_i[2:0] & align_mask);
  assign in_sq      = addr_i[TOP:TOP-5] == 6'b111000;
  assign is_data    = kind_i != ACC_FETCH;
  assign is_write   = kind_i == ACC_WRITE;
  // P1, P2, P4 segments are never translated
  assign seg_bypass = (addr_i[TOP:TOP-2] == 3'b100) || (addr_i[TOP:TOP-2] == 3'b101) ||
                      (addr_i[TOP:TOP-2] == 3'b111);
  assign priv_win   = priv_i && (addr_i[TOP:TOP-5] == 6'b011111);
  assign line_addr  = {addr_i[TOP:LINE_SH], {LINE_SH{1'b0}}};
  assign sq_base    = addr_i[LINE_SH] ? sq_base1_i : sq_base0_i;

  always_comb begin
    err_o   = ERR_NONE;
    phys_o  = addr_i;
    use_tlb = 1'b0;
    if (misal) begin
      err_o = ERR_BAD;
    end else if (in_sq && is_data) begin
      if ((addr_i[1:0] != 2'b00) || (sq_user_lock_i && !priv_i)) begin
        err_o = ERR_BAD;
      end else if (!xlat_en_i) begin
        phys_o = sq_base + line_addr;
      end else begin
        use_tlb = 1'b1;
        phys_o  = {tlb_addr_i[TOP:LINE_SH], {LINE_SH{1'b0}}};
      end
    end else if (!priv_i && addr_i[TOP]) begin
      err_o = ERR_BAD;
    end else if (priv_win || !xlat_en_i || seg_bypass) begin
      phys_o = addr_i;
    end else begin
      use_tlb = 1'b1;
      phys_o  = tlb_addr_i;
    end

    if (use_tlb) begin
      if (tlb_multi_i)                    err_o = ERR_MHIT;
      else if (!tlb_hit_i)                err_o = ERR_MISS;
      else if (!tlb_pr_i[1] && !priv_i)   err_o = ERR_PROT;
      else if (is_write && !tlb_pr_i[0])  err_o = ERR_PROT;
      else if (is_write && !tlb_dirty_i)  err_o = ERR_FW;
    end
  end
endmodule

// File: rtl/mmu_chk_excenc.sv
module mmu_chk_excenc
  import mmu_chk_pkg::*;
(
  input  acc_err_e         err_i,
  input  logic [1:0]       kind_i,
  output logic             is_exc_o,
  output logic             is_mhit_o,
  output logic [EXC_W-1:0] code_o,
  output logic [EXC_W-1:0] vec_o
);
  logic wr;
  assign wr = kind_i == ACC_WRITE;

  always_comb begin
    is_exc_o  = 1'b1;
    is_mhit_o = 1'b0;
    code_o    = '0;
    vec_o     = VEC_OTHER;
    unique case (err_i)
      ERR_MISS: begin code_o = wr ? EV_MISS_W : EV_MISS_R; vec_o = VEC_MISS; end
      ERR_PROT: code_o = wr ? EV_PROT_W : EV_PROT_R;
      ERR_FW:   code_o = EV_FW;
      ERR_BAD:  code_o = wr ? EV_BAD_W : EV_BAD_R;
      ERR_MHIT: begin is_exc_o = 1'b0; is_mhit_o = 1'b1; vec_o = '0; end
      default:  begin is_exc_o = 1'b0; vec_o = '0; end
    endcase
  end
endmodule

// File: rtl/mmu_chk_fault_reg.sv
module mmu_chk_fault_reg #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int CODE_W     = 12,
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_exc_i,
  input  logic              is_mhit_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] vec_i,
  input  logic [ADDR_W-1:0] phys_i,
  output logic              done_o,
  output logic              exc_o,
  output logic              mhit_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] vec_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic [ADDR_W-1:0] tea_o,
  output logic [VPN_W-1:0]  vpn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      exc_o  <= 1'b0;
      mhit_o <= 1'b0;
      code_o <= '0;
      vec_o  <= '0;
      phys_o <= '0;
    end else begin
      done_o <= valid_i;
      exc_o  <= valid_i & is_exc_i;
      mhit_o <= valid_i & is_mhit_i;
      if (valid_i) begin
        code_o <= code_i;
        vec_o  <= vec_i;
        phys_o <= phys_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tea_o <= '0;
      vpn_o <= '0;
    end else if (valid_i && (is_exc_i || is_mhit_i)) begin
      tea_o <= addr_i;
      vpn_o <= addr_i[ADDR_W-1:PAGE_SHIFT];
    end
  end
endmodule

// File: rtl/mmu_access_checker.sv
module mmu_access_checker
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int LINE_SH    = 5,
  localparam int VPN_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        kind_i,
  input  logic              priv_i,
  input  logic              xlat_en_i,
  input  logic              sq_user_lock_i,
  input  logic [ADDR_W-1:0] sq_base0_i,
  input  logic [ADDR_W-1:0] sq_base1_i,
  input  logic              tlb_hit_i,
  input  logic              tlb_multi_i,
  input  logic [ADDR_W-1:0] tlb_addr_i,
  input  logic [1:0]        tlb_pr_i,
  input  logic              tlb_dirty_i,
  output logic              done_o,
  output logic              exc_o,
  output logic              mhit_o,
  output logic [EXC_W-1:0]  exc_code_o,
  output logic [EXC_W-1:0]  exc_vec_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic [ADDR_W-1:0] tea_o,
  output logic [VPN_W-1:0]  vpn_o
);
  acc_err_e          err;
  logic [ADDR_W-1:0] phys_d;
  logic              is_exc, is_mhit;
  logic [EXC_W-1:0]  code_d, vec_d;

  mmu_chk_region #(.ADDR_W(ADDR_W), .LINE_SH(LINE_SH)) i_region (
    .addr_i, .size_i, .kind_i, .priv_i, .xlat_en_i, .sq_user_lock_i,
    .sq_base0_i, .sq_base1_i, .tlb_hit_i, .tlb_multi_i, .tlb_addr_i,
    .tlb_pr_i, .tlb_dirty_i,
    .err_o (err),
    .phys_o(phys_d)
  );

  mmu_chk_excenc i_excenc (
    .err_i    (err),
    .kind_i,
    .is_exc_o (is_exc),
    .is_mhit_o(is_mhit),
    .code_o   (code_d),
    .vec_o    (vec_d)
  );

  mmu_chk_fault_reg #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .CODE_W(EXC_W)) i_fault (
    .clk_i, .rst_ni, .valid_i, .addr_i,
    .is_exc_i (is_exc),
    .is_mhit_i(is_mhit),
    .code_i   (code_d),
    .vec_i    (vec_d),
    .phys_i   (phys_d),
    .done_o, .exc_o, .mhit_o,
    .code_o   (exc_code_o),
    .vec_o    (exc_vec_o),
    .phys_o, .tea_o, .vpn_o
  );
endmodule

// File: rtl/mmu_access_checker_sva.sv
module mmu_access_checker_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] addr_i,
  input logic [1:0]  size_i,
  input logic        xlat_en_i,
  input logic        tlb_multi_i,
  input logic        done_o,
  input logic        exc_o,
  input logic        mhit_o,
  input logic [11:0] exc_code_o,
  input logic [11:0] exc_vec_o,
  input logic [31:0] phys_o,
  input logic [31:0] tea_o,
  input logic [21:0] vpn_o
);
  // R11
  done_follows_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R11
  verdict_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o || mhit_o) |-> done_o && !(exc_o && mhit_o));
  // R10
  tea_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o || mhit_o) |-> (tea_o == $past(addr_i)) && (vpn_o == tea_o[31:10]));
  // R10
  tea_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_o || mhit_o) |-> $stable(tea_o) && $stable(vpn_o));
  // R9
  vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> exc_vec_o == (((exc_code_o == 12'h040) || (exc_code_o == 12'h060)) ? 12'h400 : 12'h100));
  // R5
  mhit_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mhit_o |-> $past(tlb_multi_i));
  // R1
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (size_i == 2'd2) && (addr_i[1:0] != 2'b00) |=>
      exc_o && ((exc_code_o == 12'h100) || (exc_code_o == 12'h0E0)));
  // R3
  no_xlat_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !xlat_en_i && (addr_i[31:26] != 6'b111000) |=>
      exc_o || (phys_o == $past(addr_i)));
endmodule

bind mmu_access_checker mmu_access_checker_sva i_sva (.*);

// File: tb/test_mmu_access_checker.sv
`timescale 1ns/1ps
module test_mmu_access_checker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0, kind_i = '0, tlb_pr_i = '0;
  logic        priv_i = 1'b0, xlat_en_i = 1'b0, sq_user_lock_i = 1'b0;
  logic [31:0] sq_base0_i = 32'h1111_0000, sq_base1_i = 32'h2222_0000, tlb_addr_i = '0;
  logic        tlb_hit_i = 1'b0, tlb_multi_i = 1'b0, tlb_dirty_i = 1'b0;
  logic        done_o, exc_o, mhit_o;
  logic [11:0] exc_code_o, exc_vec_o;
  logic [31:0] phys_o, tea_o;
  logic [21:0] vpn_o;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] exp_tea = '0;

  mmu_access_checker i_mmu_access_checker (.*);

  always #10 clk_i = ~clk_i;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog R11 actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] addr_pick(int i);
    case (i)
      0: return 32'h0000_1000;  1: return 32'h0000_1001;
      2: return 32'h0000_1002;  3: return 32'h0000_1004;
      4: return 32'h4000_2006;  5: return 32'h7C00_0010;
      6: return 32'h7BFF_FFF8;  7: return 32'h8000_0000;
      8: return 32'hA000_0008;  9: return 32'hC000_0100;
      10: return 32'hE000_0020; 11: return 32'hE3FF_FFE4;
      12: return 32'hE400_0000; 13: return 32'hFF00_0002;
      14: return 32'hE000_0001; default: return 32'h7FFF_FFF8;
    endcase
  endfunction

  // err: 0 none 1 bad 2 miss 3 multi 4 prot 5 first-write
  task automatic model(input logic [31:0] a, input int sz, input int kd, input bit pv,
                       input bit at, input bit lk, input int tc,
                       output int err, output logic [31:0] ph, output string tag);
    bit hit, multi, dirty, tlb, wr, sq;
    int pr;
    logic [31:0] ta;
    hit = tc >= 2; multi = tc == 1;
    pr = (tc >= 2) ? (tc - 2) / 2 : 0;
    dirty = (tc >= 2) ? ((tc - 2) % 2) : 0;
    ta = a ^ 32'h0135_7000;
    wr = kd == 2;
    sq = (a >= 32'hE000_0000) && (a <= 32'hE3FF_FFFF) && kd != 0;
    err = 0; ph = a; tlb = 0; tag = "R3";
    if (a % (32'd1 << sz) != 0) begin err = 1; tag = "R1"; end
    else if (sq) begin
      tag = "R4";
      if (a % 4 != 0 || (lk && !pv)) err = 1;
      else if (!at) ph = ((a / 32) % 2 ? sq_base1_i : sq_base0_i) + (a / 32) * 32;
      else begin tlb = 1; ph = (ta / 32) * 32; end
    end else if (!pv && a >= 32'h8000_0000) begin err = 1; tag = "R2"; end
    else if (pv && a >= 32'h7C00_0000 && a <= 32'h7FFF_FFFF) ph = a;
    else if (!at || (a / 32'h2000_0000) inside {4, 5, 7}) ph = a;
    else begin tlb = 1; ph = ta; tag = "R5"; end
    if (tlb) begin
      if (multi) begin err = 3; tag = "R5"; end
      else if (!hit) begin err = 2; tag = "R5"; end
      else if (pr < 2 && !pv) begin err = 4; tag = "R6"; end
      else if (wr && pr % 2 == 0) begin err = 4; tag = "R7"; end
      else if (wr && !dirty) begin err = 5; tag = "R7"; end
    end
  endtask

  initial begin
    #35 rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (done_o || exc_o || mhit_o || tea_o != 0 || vpn_o != 0 || exc_code_o != 0) begin
      fails++;
      $display("FAIL reset R11 actual done=%0b exc=%0b tea=%h expected all zero", done_o, exc_o, tea_o);
    end
    for (int ai = 0; ai < 16; ai++)
    for (int sz = 0; sz < 4; sz++)
    for (int kd = 0; kd < 3; kd++)
    for (int pv = 0; pv < 2; pv++)
    for (int at = 0; at < 2; at++)
    for (int lk = 0; lk < 2; lk++)
    for (int tc = 0; tc < 10; tc++) begin
      int e; logic [31:0] ph; string tag;
      logic [11:0] ec, ev; bit ex, mh, bad;
      addr_i = addr_pick(ai); size_i = 2'(sz); kind_i = 2'(kd);
      priv_i = pv[0]; xlat_en_i = at[0]; sq_user_lock_i = lk[0];
      tlb_multi_i = tc == 1; tlb_hit_i = tc >= 2;
      tlb_pr_i = (tc >= 2) ? 2'((tc - 2) / 2) : 2'd0;
      tlb_dirty_i = (tc >= 2) ? ((tc - 2) % 2 == 1) : 1'b0;
      tlb_addr_i = addr_i ^ 32'h0135_7000;
      valid_i = 1'b1;
      model(addr_i, sz, kd, pv[0], at[0], lk[0], tc, e, ph, tag);
      ex = e inside {1, 2, 4, 5}; mh = e == 3;
      // R8 event code table, R9 vectors
      case (e)
        1: begin ec = (kd == 2) ? 12'h100 : 12'h0E0; ev = 12'h100; end
        2: begin ec = (kd == 2) ? 12'h060 : 12'h040; ev = 12'h400; end
        4: begin ec = (kd == 2) ? 12'h0C0 : 12'h0A0; ev = 12'h100; end
        5: begin ec = 12'h080; ev = 12'h100; end
        default: begin ec = 12'h000; ev = 12'h000; end
      endcase
      if (ex || mh) exp_tea = addr_i;   // R10
      @(posedge clk_i); #2;
      checks++;
      bad = (done_o !== 1'b1) || (exc_o !== ex) || (mhit_o !== mh) ||
            (exc_code_o !== ec) || (exc_vec_o !== ev) || (tea_o !== exp_tea) ||
            (vpn_o !== exp_tea[31:10]) || (!ex && !mh && phys_o !== ph);
      if (bad) begin
        fails++;
        $display("FAIL %s (R8 R9 R10 R11) a=%h sz=%0d k=%0d pv=%0d at=%0d lk=%0d tc=%0d actual exc=%0b mh=%0b code=%h vec=%h phys=%h tea=%h expected exc=%0b mh=%0b code=%h vec=%h phys=%h tea=%h",
                 tag, addr_i, sz, kd, pv, at, lk, tc, exc_o, mhit_o, exc_code_o, exc_vec_o,
                 phys_o, tea_o, ex, mh, ec, ev, ph, exp_tea);
      end
      @(negedge clk_i);
    end
    // R11 and R10: idle cycle gives no verdict and keeps the fault address
    valid_i = 1'b0;
    addr_i = 32'hDEAD_BEE0;
    @(posedge clk_i); #2;
    checks++;
    if (done_o || exc_o || mhit_o || tea_o !== exp_tea) begin
      fails++;
      $display("FAIL idle R11 R10 actual done=%0b exc=%0b tea=%h expected done=0 exc=0 tea=%h",
               done_o, exc_o, tea_o, exp_tea);
    end
    finish_run();
  end
endmodule